// File: doc/BRIEF.md
# Multi-Comparator Event Timer

A memory-mapped event timer built around one free-running up-counter that is shared by a parameterized set of comparators. Each comparator watches the counter. When the counter reaches the comparator's programmed value, the comparator raises its own interrupt line. A comparator runs either one-shot or periodic. In periodic mode a hidden period register is added to the compare value on every match, so the comparator re-arms itself without any software action.

Software reaches the block through a word-addressed 32-bit register port. Writes take one clock. Reads are combinational from the address. The map is as follows:
- word 0 holds the capability fields.
- word 1 holds the tick period in femtoseconds.
- word 2 is the global configuration (bit 0 = run).
- word 3 is the interrupt status, one bit per comparator at the comparator's index.
- words 4 and 5 are the counter, low and high halves.
- comparator k occupies words 8+4k (configuration), 9+4k (compare low) and 10+4k (compare high).

A write to compare-high only stages the upper half. The following compare-low write commits the whole 64-bit value.

Configuration bits:

| Bit | Meaning |
|---|---|
| 0 | interrupt enable |
| 1 | level mode when 1, edge mode when 0 |
| 2 | periodic select |
| 3 | periodic-capable, read-only |
| 4 | value-set |
| 5 | 32-bit force |
| 31:6 | route, stored and read back |

Top module: `evtimer`

## Requirements
- R1: While run (word 2 bit 0) is 1, the counter rises by exactly one per clock. After reset the counter reads 0.
- R2: While run is 0, the counter holds its value. Writes to words 4 and 5 load the counter only while run is 0. While run is 1 those writes are ignored.
- R3: Word 0 reads the comparator count minus one in bits 7:0 and a 1 in bit 8 for a 64-bit counter. Word 1 reads the tick period in femtoseconds.
- R4: On a periodic comparator with value-set (bit 4) at 1, a compare-low write loads the absolute time of the first match, and value-set then reads 0. Each later compare-low write loads only the period.
- R5: A periodic comparator fires at its first due time and then every period ticks. The compare register reads old value plus period from the cycle the match shows on irq.
- R6: On a comparator that is not periodic-capable, bit 3 reads 0 and the periodic bit reads 0. That comparator fires only once per programmed value, and every compare-low write loads the compare value.
- R7: In level mode, a match sets status bit k and holds irq[k] high until 1 is written to bit k of word 3.
- R8: In edge mode, each match drives irq[k] high for exactly one clock and leaves status bit k at 0.
- R9: The interrupt enable bit gates only the irq output. Matching and setting the status bit continue while it is 0, and the output rises as soon as it is set.
- R10: With 32-bit force (bit 5), the comparator matches on the low 32 counter bits only, and its compare-high word reads 0.
- R11: Irq[k] and the counter value change on the same clock edge. The interrupt for a match is visible in the same cycle the counter first reads the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | N_CMP | One interrupt line per comparator |

## Verification
Some properties are checked on every cycle:
- the counter steps by exactly one while running and holds while stopped with no write;
- value-set always drops after the compare-low write it qualifies;
- a periodic match always advances the compare value by the period;
- a level status bit never falls without a clear.

Other behaviours need the bench's timed scenarios:
- the exact match cycles of one-shot, periodic and 32-bit-forced comparators;
- the single-cycle width of edge pulses;
- counter writes being ignored while running;
- a non-capable comparator falling back to one-shot.

// File: rtl/evt_pkg.sv
package evt_pkg;
   localparam int unsigned A_CAPS     = 0;
   localparam int unsigned A_TICK     = 1;
   localparam int unsigned A_GCFG     = 2;
   localparam int unsigned A_STAT     = 3;
   localparam int unsigned A_CNTL     = 4;
   localparam int unsigned A_CNTH     = 5;
   localparam int unsigned A_CMP0     = 8;
   localparam int unsigned CMP_STRIDE = 4;
   localparam int unsigned O_CFG      = 0;
   localparam int unsigned O_CMPL     = 1;
   localparam int unsigned O_CMPH     = 2;
   localparam int unsigned B_IE       = 0;
   localparam int unsigned B_LVL      = 1;
   localparam int unsigned B_PER      = 2;
   localparam int unsigned B_CAP      = 3;
   localparam int unsigned B_VS       = 4;
   localparam int unsigned B_F32      = 5;
   localparam int unsigned B_RT       = 6;
   localparam int unsigned RT_W       = 26;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
   parameter int unsigned CNT_W = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   output logic [63:0] cnt,
   output logic [63:0] cnt_nxt
);
   localparam logic [63:0] FULL = (CNT_W == 64) ? {64{1'b1}} : {32'h0, {32{1'b1}}};

   logic hi_ok;

   generate
      if (CNT_W == 64) begin : g_wide
         assign hi_ok = wr_hi;
      end else begin : g_narrow
         assign hi_ok = 1'b0;
      end
   endgenerate

   assign cnt_nxt = (cnt + 64'd1) & FULL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (run) begin
         cnt <= cnt_nxt;
      end else if (wr_lo) begin
         cnt[31:0] <= wdata;
      end else if (hi_ok) begin
         cnt[63:32] <= wdata;
      end
   end

   p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> cnt == (($past(cnt) + 64'd1) & FULL));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: rtl/evt_cmp.sv
module evt_cmp
   import evt_pkg::*;
#(
   parameter int unsigned CNT_W    = 64,
   parameter bit          PERIODIC = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic [63:0] cnt_nxt,
   input  logic        cfg_we,
   input  logic        lo_we,
   input  logic        hi_we,
   input  logic        st_clr,
   input  logic [31:0] wdata,
   output logic [31:0] cfg_rd,
   output logic [63:0] cmp_rd,
   output logic        st,
   output logic        irq
);
   localparam logic [63:0] FULL = (CNT_W == 64) ? {64{1'b1}} : {32'h0, {32{1'b1}}};
   localparam logic [63:0] LOW  = {32'h0, {32{1'b1}}};

   logic            ie_q, lvl_q, per_q, vs_q, f32_q, pulse_q;
   logic [RT_W-1:0] rt_q;
   logic [63:0]     cmp_q, plen_q, mask, wval;
   logic [31:0]     stage_q;
   logic            hit;

   assign mask   = f32_q ? LOW : FULL;
   assign wval   = {stage_q, wdata} & mask;
   assign hit    = run && ((cnt_nxt & mask) == (cmp_q & mask));
   assign cmp_rd = cmp_q & mask;
   assign irq    = ie_q & (lvl_q ? st : pulse_q);

   generate
      if (PERIODIC) begin : g_per
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      per_q <= 1'b0;
            else if (cfg_we) per_q <= wdata[B_PER];
         end
      end else begin : g_oneshot
         assign per_q = 1'b0;
      end
   endgenerate

   always_comb begin
      cfg_rd             = '0;
      cfg_rd[B_IE]       = ie_q;
      cfg_rd[B_LVL]      = lvl_q;
      cfg_rd[B_PER]      = per_q;
      cfg_rd[B_CAP]      = PERIODIC;
      cfg_rd[B_VS]       = vs_q;
      cfg_rd[B_F32]      = f32_q;
      cfg_rd[B_RT +: RT_W] = rt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         lvl_q <= 1'b0;
         vs_q  <= 1'b0;
         f32_q <= 1'b0;
         rt_q  <= '0;
      end else if (cfg_we) begin
         ie_q  <= wdata[B_IE];
         lvl_q <= wdata[B_LVL];
         vs_q  <= wdata[B_VS];
         f32_q <= wdata[B_F32];
         rt_q  <= wdata[B_RT +: RT_W];
      end else if (lo_we) begin
         vs_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         cmp_q   <= '0;
         plen_q  <= '0;
      end else begin
         if (hi_we) stage_q <= wdata;
         if (lo_we) begin
            if (per_q && !vs_q) plen_q <= wval;
            else                cmp_q  <= wval;
         end else if (hit && per_q) begin
            cmp_q <= (cmp_q + plen_q) & mask;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= hit && !lvl_q;
         if (hit && lvl_q) st <= 1'b1;
         else if (st_clr)  st <= 1'b0;
      end
   end

   p_vs_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |=> !vs_q);

   p_period_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && per_q && !lo_we) |=> cmp_q == (($past(cmp_q) + $past(plen_q)) & $past(mask)));

   p_level_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st && !st_clr) |=> st);
endmodule

// File: rtl/evtimer.sv
module evtimer
   import evt_pkg::*;
#(
   parameter int unsigned N_CMP   = 3,
   parameter int unsigned CNT_W   = 64,
   parameter logic [31:0] TICK_FS = 32'd10_000_000,
   parameter logic [31:0] PER_CAP = 32'h0000_0003,
   parameter int unsigned ADDR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [N_CMP-1:0]  irq
);
   localparam int unsigned WORDS = A_CMP0 + CMP_STRIDE * N_CMP;

   generate
      if (N_CMP < 1 || N_CMP > 32) begin : g_bad_n
         $error("evtimer: N_CMP must be 1..32");
      end
      if (CNT_W != 32 && CNT_W != 64) begin : g_bad_w
         $error("evtimer: CNT_W must be 32 or 64");
      end
      if (WORDS > (1 << ADDR_W)) begin : g_bad_a
         $error("evtimer: ADDR_W too small for the map");
      end
   endgenerate

   logic              run_q;
   logic [63:0]       cnt, cnt_nxt;
   logic [N_CMP-1:0]  st_vec;
   logic [31:0]       cfg_rd [N_CMP];
   logic [63:0]       cmp_rd [N_CMP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else if (reg_wr && reg_addr == ADDR_W'(A_GCFG)) run_q <= reg_wdata[0];
   end

   evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .wr_lo   (reg_wr && reg_addr == ADDR_W'(A_CNTL)),
      .wr_hi   (reg_wr && reg_addr == ADDR_W'(A_CNTH)),
      .wdata   (reg_wdata),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt)
   );

   for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
      localparam int unsigned BASE = A_CMP0 + CMP_STRIDE * k;
      evt_cmp #(.CNT_W(CNT_W), .PERIODIC(PER_CAP[k])) u_cmp (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run_q),
         .cnt_nxt (cnt_nxt),
         .cfg_we  (reg_wr && reg_addr == ADDR_W'(BASE + O_CFG)),
         .lo_we   (reg_wr && reg_addr == ADDR_W'(BASE + O_CMPL)),
         .hi_we   (reg_wr && reg_addr == ADDR_W'(BASE + O_CMPH)),
         .st_clr  (reg_wr && reg_addr == ADDR_W'(A_STAT) && reg_wdata[k]),
         .wdata   (reg_wdata),
         .cfg_rd  (cfg_rd[k]),
         .cmp_rd  (cmp_rd[k]),
         .st      (st_vec[k]),
         .irq     (irq[k])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_CAPS))
         reg_rdata = {23'h0, (CNT_W == 64), 8'(N_CMP - 1)};
      else if (reg_addr == ADDR_W'(A_TICK)) reg_rdata = TICK_FS;
      else if (reg_addr == ADDR_W'(A_GCFG)) reg_rdata = {31'h0, run_q};
      else if (reg_addr == ADDR_W'(A_STAT)) reg_rdata = 32'(st_vec);
      else if (reg_addr == ADDR_W'(A_CNTL)) reg_rdata = cnt[31:0];
      else if (reg_addr == ADDR_W'(A_CNTH)) reg_rdata = cnt[63:32];
      for (int k = 0; k < N_CMP; k++) begin
         if (reg_addr == ADDR_W'(A_CMP0 + CMP_STRIDE * k + O_CFG))  reg_rdata = cfg_rd[k];
         if (reg_addr == ADDR_W'(A_CMP0 + CMP_STRIDE * k + O_CMPL)) reg_rdata = cmp_rd[k][31:0];
         if (reg_addr == ADDR_W'(A_CMP0 + CMP_STRIDE * k + O_CMPH)) reg_rdata = cmp_rd[k][63:32];
      end
   end
endmodule

// File: tb/test_evtimer.sv
`timescale 1ns/1ps
module test_evtimer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  irq;
   int total = 0;
   int bad = 0;

   evtimer i_evtimer (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   always #2 clk = ~clk;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = 6'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 6'(a);
      #0.1;
      d = reg_rdata;
   endtask

   task automatic zero_stop();
      wr(2, 0); wr(4, 0); wr(5, 0); wr(3, 32'h7);
   endtask

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state and capabilities
      chk("R1 reset irq", 64'(irq), 0);
      rd(4, v); chk("R1 reset counter", 64'(v), 0);
      rd(3, v); chk("R7 reset status", 64'(v), 0);
      rd(0, v); chk("R3 caps word", 64'(v), 64'h102);
      rd(1, v); chk("R3 tick period", 64'(v), 64'd10_000_000);

      // one-shot level on comparator 2 at 10
      zero_stop();
      wr(16, 3); wr(18, 0); wr(17, 10); wr(2, 1);
      for (int j = 1; j <= 20; j++) begin
         @(negedge clk);
         chk("R7 R11 oneshot level irq", 64'(irq[2]), 64'(j >= 10));
      end
      rd(4, v); chk("R1 counter count", 64'(v), 20);
      wr(4, 32'hDEAD);
      rd(4, v); chk("R2 write ignored while running", 64'(v), 22);
      wr(3, 32'h4);
      chk("R7 w1c drops irq", 64'(irq[2]), 0);
      rd(3, v); chk("R7 w1c status", 64'(v[2]), 0);
      wr(2, 0);
      rd(4, v); chk("R2 stop value", 64'(v), 26);
      repeat (5) @(negedge clk);
      rd(4, v); chk("R2 hold while stopped", 64'(v), 26);
      wr(4, 100); rd(4, v); chk("R2 write low stopped", 64'(v), 100);
      wr(5, 3); rd(5, v); chk("R2 write high stopped", 64'(v), 3);

      // periodic edge on comparator 0: first due 5, period 7
      zero_stop();
      wr(8, 32'h15); wr(10, 0); wr(9, 5);
      rd(8, v); chk("R4 value-set cleared", 64'(v), 64'hD);
      wr(9, 7);
      rd(9, v); chk("R4 period write keeps due", 64'(v), 5);
      wr(2, 1);
      for (int j = 1; j <= 40; j++) begin
         @(negedge clk);
         chk("R5 R8 periodic edge irq", 64'(irq[0]), 64'(j >= 5 && (j - 5) % 7 == 0));
         if (j == 6) begin
            rd(9, v); chk("R5 compare advanced", 64'(v), 12);
            rd(3, v); chk("R8 edge leaves status", 64'(v[0]), 0);
         end
      end
      wr(2, 0); wr(8, 0);

      // comparator 2 has no periodic capability
      zero_stop();
      wr(16, 32'h17);
      rd(16, v); chk("R6 periodic bit reads zero", 64'(v), 64'h13);
      wr(18, 0); wr(17, 4); wr(2, 1);
      for (int j = 1; j <= 30; j++) begin
         @(negedge clk);
         chk("R6 oneshot fallback irq", 64'(irq[2]), 64'(j >= 4));
      end
      wr(3, 32'h4);
      for (int j = 0; j < 20; j++) begin
         @(negedge clk);
         chk("R6 no refire", 64'(irq[2]), 0);
      end
      rd(17, v); chk("R6 compare not advanced", 64'(v), 4);
      wr(2, 0); wr(16, 0);

      // enable gate on comparator 1
      zero_stop();
      wr(12, 32'h2); wr(14, 0); wr(13, 3); wr(2, 1);
      repeat (6) @(negedge clk);
      chk("R9 gated irq low", 64'(irq[1]), 0);
      rd(3, v); chk("R9 status still set", 64'(v[1]), 1);
      wr(12, 32'h3);
      chk("R9 irq after enable", 64'(irq[1]), 1);
      wr(2, 0);

      // 32-bit force on comparator 1
      wr(4, 32'hFFFF_FFF0); wr(5, 1); wr(3, 32'h7);
      wr(12, 32'h23); wr(14, 5); wr(13, 32'hFFFF_FFF8);
      rd(14, v); chk("R10 compare high reads zero", 64'(v), 0);
      wr(2, 1);
      for (int j = 1; j <= 12; j++) begin
         @(negedge clk);
         chk("R10 low-32 match irq", 64'(irq[1]), 64'(j >= 8));
      end
      wr(2, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule